// File: doc/BRIEF.md
# Sequenced Stimulus Sample Generator

This block drives a circuit under test with a fixed list of sample words, one word per clock cycle. The list is set at elaboration time as a packed table of `NUM_SAMPLES` entries, each `SAMPLE_W` bits wide. Entry 0 sits in the least significant slice. The block has no data inputs. It has only a clock and a synchronous, active-high reset. Its one output is the sample currently presented.

While reset is high, the output shows entry 0. After reset drops, entry 0 stays for one more cycle. The block then steps through the list in order, one entry per cycle. When it reaches the final entry it stays there for good and does not wrap. Raising reset again at any point restarts the sequence from entry 0.

Top module: `stim_sequencer`

## Requirements
- R1: While `rst` is high, `sample_o` equals table entry 0. This holds from the very first cycle, before any clock edge has been seen.
- R2: In the first cycle after `rst` is sampled low, `sample_o` still equals entry 0. A one-cycle reset therefore shows entry 0 on two consecutive cycles.
- R3: From then on, `sample_o` moves forward by exactly one table entry per clock cycle, in ascending index order. Entry k lives in bits `[k*SAMPLE_W +: SAMPLE_W]` of `SAMPLE_TABLE`.
- R4: Once entry `NUM_SAMPLES-1` is presented, it stays on `sample_o` for every later cycle until the next reset, with no wrap to entry 0.
- R5: Asserting `rst` in the middle of the sequence or during the hold returns `sample_o` to entry 0 and restarts the sequence as in R2 and R3.
- R6: The internal sample index is `max(1, ceil(log2(NUM_SAMPLES)))` bits wide. It saturates at `NUM_SAMPLES-1` and never goes past it.
- R7: With `NUM_SAMPLES = 1`, `sample_o` equals the single table entry in every cycle, whether in reset or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output changes only after its rising edge or with `rst` |
| rst | input | 1 | Synchronous reset, active high; restarts the sequence |
| sample_o | output | SAMPLE_W | Sample word currently presented |

## Verification
The bench applies a one-cycle reset and then a long free run. This separates the extra cycle of entry 0 from an early start, and it separates the final hold from a wrap or an index overflow. A multi-cycle reset confirms that entry 0 is shown during reset as well as for exactly one cycle after it. Resets issued during the hold and in mid-sequence show whether the restart works from any index. A second instance with a single entry checks the degenerate constant case.

// File: rtl/stim_seq_pkg.sv
package stim_seq_pkg;

    // Width of an index able to address n entries (at least one bit).
    function automatic int unsigned idx_width(input int unsigned n);
        if (n <= 1) begin
            return 1;
        end
        return $clog2(n);
    endfunction

endpackage

// File: rtl/sample_index_ctr.sv
module sample_index_ctr
    import stim_seq_pkg::*;
#(
    parameter int unsigned NUM_SAMPLES = 4,
    localparam int unsigned IDX_W = idx_width(NUM_SAMPLES)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SAMPLES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ctr_state_t;

    ctr_state_t state_d;
    ctr_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.idx = '0;
        end else if (state_q.idx != LAST_IDX) begin
            state_d.idx = state_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign idx_o = state_q.idx;

    // R6: the index never leaves the table
    assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        state_q.idx <= LAST_IDX);

    // R3: below the end, the index steps by one per cycle
    assert_idx_step_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q.idx < LAST_IDX) |=> (state_q.idx == $past(state_q.idx) + 1'b1));

    // R4: the final index is held, no wrap
    assert_idx_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q.idx == LAST_IDX) |=> (state_q.idx == LAST_IDX));

    // R5: a sampled reset always yields index zero
    assert_idx_restart_R5: assert property (@(posedge clk)
        rst |=> (state_q.idx == '0));

endmodule

// File: rtl/sample_word_mux.sv
module sample_word_mux
    import stim_seq_pkg::*;
#(
    parameter int unsigned NUM_SAMPLES = 4,
    parameter int unsigned SAMPLE_W    = 8,
    parameter logic [NUM_SAMPLES*SAMPLE_W-1:0] SAMPLE_TABLE = '0,
    localparam int unsigned IDX_W = idx_width(NUM_SAMPLES)
) (
    input  logic [IDX_W-1:0]    sel_i,
    output logic [SAMPLE_W-1:0] word_o
);

    logic [SAMPLE_W-1:0] words [NUM_SAMPLES];

    for (genvar k = 0; k < NUM_SAMPLES; k++) begin : g_slice
        assign words[k] = SAMPLE_TABLE[k*SAMPLE_W +: SAMPLE_W];
    end

    always_comb begin
        word_o = words[0];
        for (int k = 1; k < NUM_SAMPLES; k++) begin
            if (sel_i == IDX_W'(k)) begin
                word_o = words[k];
            end
        end
    end

endmodule

// File: rtl/stim_sequencer.sv
module stim_sequencer
    import stim_seq_pkg::*;
#(
    parameter int unsigned NUM_SAMPLES = 4,
    parameter int unsigned SAMPLE_W    = 8,
    parameter logic [NUM_SAMPLES*SAMPLE_W-1:0] SAMPLE_TABLE = {8'h84, 8'h63, 8'h42, 8'h21}
) (
    input  logic                clk,
    input  logic                rst,
    output logic [SAMPLE_W-1:0] sample_o
);

    localparam int unsigned IDX_W = idx_width(NUM_SAMPLES);
    localparam logic [SAMPLE_W-1:0] FIRST_WORD = SAMPLE_TABLE[SAMPLE_W-1:0];

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] sel_d;

    sample_index_ctr #(
        .NUM_SAMPLES(NUM_SAMPLES)
    ) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .idx_o(idx_q)
    );

    // Reset forces entry 0 even before the first edge has loaded the index.
    always_comb begin
        sel_d = idx_q;
        if (rst) begin
            sel_d = '0;
        end
    end

    sample_word_mux #(
        .NUM_SAMPLES (NUM_SAMPLES),
        .SAMPLE_W    (SAMPLE_W),
        .SAMPLE_TABLE(SAMPLE_TABLE)
    ) u_mux (
        .sel_i (sel_d),
        .word_o(sample_o)
    );

    // R2: the cycle right after reset release still shows entry 0
    assert_first_after_release_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sample_o == FIRST_WORD));

    // R1: a reset cycle is followed by entry 0 on the output
    assert_reset_word_R1: assert property (@(posedge clk)
        rst |=> (sample_o == FIRST_WORD));

endmodule

// File: tb/tb_stim_sequencer.sv
module tb_stim_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 6;
    localparam int W   = 8;
    localparam logic [N*W-1:0] TBL = {8'hA7, 8'h5E, 8'h4D, 8'h3C, 8'h22, 8'h11};
    localparam logic [W-1:0]   SOLO = 8'h9B;

    typedef struct {
        logic [W-1:0] value;
        string        req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] sample_o;
    logic [W-1:0] solo_o;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   m_idx  = 0;
    bit   prev_rst = 1'b1;
    bit   done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stim_sequencer #(.NUM_SAMPLES(N), .SAMPLE_W(W), .SAMPLE_TABLE(TBL)) dut (
        .clk(clk), .rst(rst), .sample_o(sample_o));

    stim_sequencer #(.NUM_SAMPLES(1), .SAMPLE_W(W), .SAMPLE_TABLE(SOLO)) dut_solo (
        .clk(clk), .rst(rst), .sample_o(solo_o));

    function automatic logic [W-1:0] entry(input int k);
        return TBL[k*W +: W];
    endfunction

    // Driver: set reset for one cycle and push the expected output of that cycle.
    task automatic step(input bit r);
        exp_t e;
        @(negedge clk);
        rst = r;
        if (r) begin
            e.value = entry(0);
            e.req   = prev_rst ? "R1" : "R5";
            m_idx   = 0;
        end else begin
            e.value = entry(m_idx);
            if (prev_rst)            e.req = "R2";
            else if (m_idx == N - 1) e.req = "R4,R6";
            else                     e.req = "R3";
            m_idx = (m_idx == N - 1) ? m_idx : m_idx + 1;
        end
        prev_rst = r;
        exp_q.push_back(e);
    endtask

    // Monitor: compare shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (sample_o !== e.value) begin
                    fails++;
                    $display("FAIL %s: sample_o=%h expected %h", e.req, sample_o, e.value);
                end
                checks++;
                if (solo_o !== SOLO) begin
                    fails++;
                    $display("FAIL R7: solo_o=%h expected %h", solo_o, SOLO);
                end
            end
        end
    end

    initial begin
        #1;
        checks++; // R1 before any clock edge
        if (sample_o !== entry(0)) begin
            fails++;
            $display("FAIL R1: sample_o=%h expected %h", sample_o, entry(0));
        end
        step(1'b1);                                   // R1 one-cycle reset
        for (int i = 0; i < 12; i++) step(1'b0);      // R2, R3, R4 hold
        for (int i = 0; i < 3; i++) step(1'b1);       // R5 reset during hold
        for (int i = 0; i < 4; i++) step(1'b0);       // restart, mid-sequence
        step(1'b1);                                   // R5 mid-sequence reset
        for (int i = 0; i < 10; i++) step(1'b0);      // run to hold again
        @(negedge clk);
        #2;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 2000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: done=0 expected 1");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule